// File: doc/BRIEF.md
# Per-Thread Squash and Trap Controller

This block sits at the retire end of a multithreaded out-of-order core and decides, for every hardware thread, when the in-flight work of that thread must be thrown away. Three sources can ask for that. A trap is taken after a programmable wait. A context-change request squashes the whole thread at once. The execute stage reports a mispredicted or faulting instruction by its sequence number. The block ranks these sources and drops any execute-stage report that is younger than what the thread already holds, so an older squash is never overridden by a younger one.

Each thread keeps a small status machine with the states idle, running, squashing the reorder buffer, waiting on a trap, and waiting on a fetch-side trap. It also keeps the youngest sequence number it has accepted into the reorder buffer. When a squash is accepted, the thread broadcasts a one-cycle pulse that carries the boundary sequence number, the restart address and a mispredict flag. It then holds a buffer-squashing flag until the reorder buffer says that its walk is finished. A single stage-active output tells the surrounding pipeline whether any thread still has squash or trap work outstanding.

Top module: `squash_trap_ctrl`

## Requirements
- R1: After reset every thread is idle with youngest sequence 0, and `sq_valid`, `rob_squashing` and `stage_active` are all 0.
- R2: A context-change request squashes the whole thread in the following cycle, even during a trap wait, and it cancels that wait. If the trap wait expires in the same cycle as a context request, the trap is served and exactly one broadcast results.
- R3: An accepted execute-stage squash gives a `sq_valid` pulse in the following cycle. The pulse carries the reported sequence number as its boundary (include flag 0), the reported redirect address and the reported mispredict flag, and `rob_squashing` rises at the same time.
- R4: An execute-stage squash is ignored if its sequence number is greater than the thread's youngest sequence, or if the thread is waiting on a trap (non-fetch kind).
- R5: With the include flag set, the boundary is the reported sequence minus one. After any execute-stage squash, the boundary becomes the thread's youngest sequence.
- R6: `rob_squashing` stays 1 until `rob_done` is seen for that thread. The thread then returns to running and the flag drops after that edge.
- R7: An insert records its sequence number as the thread's youngest and moves an idle thread to running. Inserts are ignored while the thread is squashing.
- R8: A whole-thread squash (trap or context) uses `head_seq - 1` as its boundary when `head_vld` is 1 and 0 otherwise. It uses `commit_pc` as the restart address and mispredict 0, and it resets the youngest sequence to 0.
- R9: A trap request sampled at edge n with latency L gives the whole-thread broadcast at edge n+L+1. Further trap requests are ignored while the wait runs.
- R10: `stage_active` is 1 exactly while some thread is squashing or waiting on a trap.
- R11: Threads are independent. A squash on one lane changes no output of another lane.
- R12: A trap request with `trap_fetch` = 1 uses the same latency but does not block execute-stage squashes. An accepted one cancels the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_latency | input | LAT_W | Cycles between trap acceptance and its squash |
| trap_req | input | NTHR | Trap request per thread |
| trap_fetch | input | NTHR | Trap is of the fetch-side kind |
| ctx_squash_req | input | NTHR | Context-change squash request per thread |
| ex_squash_vld | input | NTHR | Execute-stage squash report valid |
| ex_squash_seq | input | NTHR*SEQ_W | Reported sequence number per thread |
| ex_squash_incl | input | NTHR | Squash includes the reporting instruction |
| ex_squash_mispred | input | NTHR | Report is a branch mispredict |
| ex_redirect_pc | input | NTHR*PC_W | Redirect address from execute |
| insert_vld | input | NTHR | Instruction inserted into the reorder buffer |
| insert_seq | input | NTHR*SEQ_W | Sequence number of the inserted instruction |
| head_vld | input | NTHR | Reorder buffer holds an instruction for the thread |
| head_seq | input | NTHR*SEQ_W | Sequence number at the buffer head |
| commit_pc | input | NTHR*PC_W | Architectural restart address |
| rob_done | input | NTHR | Reorder buffer squash walk finished |
| sq_valid | output | NTHR | One-cycle squash broadcast |
| sq_seq | output | NTHR*SEQ_W | Squash boundary sequence number |
| sq_pc | output | NTHR*PC_W | Restart address |
| sq_mispred | output | NTHR | Broadcast stems from a mispredict |
| rob_squashing | output | NTHR | Thread is squashing the reorder buffer |
| stage_active | output | 1 | Some thread has squash or trap work |

## Verification
The assertions assume that `rob_done` only matters while a thread is squashing. They also assume that `head_seq` is nonzero whenever `head_vld` is 1, so that the whole-thread boundary never wraps. The stimulus raises `rob_done` only after a broadcast, and it uses head sequence numbers well above zero. Trap and context requests are timed by hand so that each ranking case occurs on purpose. Every expected value is counted in edges from the moment the request is sampled.

// File: rtl/sqtc_pkg.sv
package sqtc_pkg;

    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_ROBSQ = 3'd2,
        ST_TRAP  = 3'd3,
        ST_FTRAP = 3'd4
    } thr_state_e;

    typedef struct packed {
        logic             valid;
        logic             whole;
        logic             mispred;
        logic [SEQ_W-1:0] bound;
        logic [PC_W-1:0]  pc;
    } squash_ev_t;

    function automatic logic [SEQ_W-1:0] whole_bound(input logic vld,
                                                     input logic [SEQ_W-1:0] hseq);
        return vld ? (hseq - 1'b1) : '0;
    endfunction

    function automatic logic [SEQ_W-1:0] self_bound(input logic [SEQ_W-1:0] seq,
                                                    input logic incl);
        return incl ? (seq - 1'b1) : seq;
    endfunction

endpackage

// File: rtl/sqtc_trap_timer.sv
module sqtc_trap_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LAT_W-1:0] latency,
    input  logic             run,
    output logic             expired
);
    logic [LAT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= latency;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = run && (cnt == '0);

    // R9: while waiting, the count falls by exactly one per cycle
    p_timer_steps_r9: assert property (@(posedge clk) disable iff (rst)
        (run && !start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sqtc_thread.sv
module sqtc_thread
    import sqtc_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LAT_W-1:0] trap_latency,
    input  logic             trap_req,
    input  logic             trap_fetch,
    input  logic             ctx_req,
    input  logic             ex_vld,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    input  logic             ex_mispred,
    input  logic [PC_W-1:0]  ex_pc,
    input  logic             ins_vld,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic             head_vld,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic [PC_W-1:0]  commit_pc,
    input  logic             rob_done,
    output squash_ev_t       ev_o,
    output logic             rob_sq_o,
    output logic             busy_o
);
    thr_state_e       st, st_n, base;
    logic [SEQ_W-1:0] yng, yng_n;
    squash_ev_t       ev_n, ev_q;
    logic             in_trap, trap_fire, ex_ok, t_start;

    assign in_trap = (st == ST_TRAP) || (st == ST_FTRAP);

    sqtc_trap_timer #(.LAT_W(LAT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (t_start),
        .latency (trap_latency),
        .run     (in_trap),
        .expired (trap_fire)
    );

    assign ex_ok = ex_vld && (st != ST_TRAP) && (ex_seq <= yng);

    always_comb begin
        base    = (st == ST_ROBSQ && rob_done) ? ST_RUN : st;
        st_n    = base;
        yng_n   = yng;
        ev_n    = '0;
        t_start = 1'b0;
        if (trap_fire || ctx_req) begin
            // trap expiry ranks first; a coincident context request merges into it
            ev_n.valid   = 1'b1;
            ev_n.whole   = 1'b1;
            ev_n.mispred = 1'b0;
            ev_n.bound   = whole_bound(head_vld, head_seq);
            ev_n.pc      = commit_pc;
            st_n         = ST_ROBSQ;
            yng_n        = '0;
        end else if (ex_ok) begin
            ev_n.valid   = 1'b1;
            ev_n.whole   = 1'b0;
            ev_n.mispred = ex_mispred;
            ev_n.bound   = self_bound(ex_seq, ex_incl);
            ev_n.pc      = ex_pc;
            st_n         = ST_ROBSQ;
            yng_n        = self_bound(ex_seq, ex_incl);
        end else begin
            if (trap_req && (base == ST_IDLE || base == ST_RUN)) begin
                st_n    = trap_fetch ? ST_FTRAP : ST_TRAP;
                t_start = 1'b1;
            end
            if (ins_vld && base != ST_ROBSQ) begin
                yng_n = ins_seq;
                if (st_n == ST_IDLE)
                    st_n = ST_RUN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            yng  <= '0;
            ev_q <= '0;
        end else begin
            st   <= st_n;
            yng  <= yng_n;
            ev_q <= ev_n;
        end
    end

    assign ev_o     = ev_q;
    assign rob_sq_o = (st == ST_ROBSQ);
    assign busy_o   = rob_sq_o || in_trap;

    // R3: every broadcast coincides with the squashing state
    p_pulse_in_squash_r3: assert property (@(posedge clk) disable iff (rst)
        ev_q.valid |-> (st == ST_ROBSQ));

    // R5: youngest sequence follows the broadcast boundary (0 for whole-thread)
    p_youngest_follows_r5: assert property (@(posedge clk) disable iff (rst)
        ev_q.valid |-> (yng == (ev_q.whole ? '0 : ev_q.bound)));

    // R4: a trap wait that neither expires nor is cancelled yields no broadcast
    p_trap_blocks_ex_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRAP && !trap_fire && !ctx_req) |=> !ev_q.valid);

    // R6: finished walk with nothing else pending returns the thread to running
    p_done_to_run_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ROBSQ && rob_done && !ctx_req && !ex_ok && !trap_req)
        |=> (st == ST_RUN));

endmodule

// File: rtl/squash_trap_ctrl.sv
module squash_trap_ctrl
    import sqtc_pkg::*;
#(
    parameter int NTHR  = 2,
    parameter int LAT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LAT_W-1:0]      trap_latency,
    input  logic [NTHR-1:0]       trap_req,
    input  logic [NTHR-1:0]       trap_fetch,
    input  logic [NTHR-1:0]       ctx_squash_req,
    input  logic [NTHR-1:0]       ex_squash_vld,
    input  logic [NTHR*SEQ_W-1:0] ex_squash_seq,
    input  logic [NTHR-1:0]       ex_squash_incl,
    input  logic [NTHR-1:0]       ex_squash_mispred,
    input  logic [NTHR*PC_W-1:0]  ex_redirect_pc,
    input  logic [NTHR-1:0]       insert_vld,
    input  logic [NTHR*SEQ_W-1:0] insert_seq,
    input  logic [NTHR-1:0]       head_vld,
    input  logic [NTHR*SEQ_W-1:0] head_seq,
    input  logic [NTHR*PC_W-1:0]  commit_pc,
    input  logic [NTHR-1:0]       rob_done,
    output logic [NTHR-1:0]       sq_valid,
    output logic [NTHR*SEQ_W-1:0] sq_seq,
    output logic [NTHR*PC_W-1:0]  sq_pc,
    output logic [NTHR-1:0]       sq_mispred,
    output logic [NTHR-1:0]       rob_squashing,
    output logic                  stage_active
);
    logic [NTHR-1:0] busy;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        squash_ev_t ev;

        sqtc_thread #(.LAT_W(LAT_W)) u_thr (
            .clk          (clk),
            .rst          (rst),
            .trap_latency (trap_latency),
            .trap_req     (trap_req[t]),
            .trap_fetch   (trap_fetch[t]),
            .ctx_req      (ctx_squash_req[t]),
            .ex_vld       (ex_squash_vld[t]),
            .ex_seq       (ex_squash_seq[t*SEQ_W +: SEQ_W]),
            .ex_incl      (ex_squash_incl[t]),
            .ex_mispred   (ex_squash_mispred[t]),
            .ex_pc        (ex_redirect_pc[t*PC_W +: PC_W]),
            .ins_vld      (insert_vld[t]),
            .ins_seq      (insert_seq[t*SEQ_W +: SEQ_W]),
            .head_vld     (head_vld[t]),
            .head_seq     (head_seq[t*SEQ_W +: SEQ_W]),
            .commit_pc    (commit_pc[t*PC_W +: PC_W]),
            .rob_done     (rob_done[t]),
            .ev_o         (ev),
            .rob_sq_o     (rob_squashing[t]),
            .busy_o       (busy[t])
        );

        assign sq_valid[t]                  = ev.valid;
        assign sq_mispred[t]                = ev.mispred;
        assign sq_seq[t*SEQ_W +: SEQ_W]     = ev.bound;
        assign sq_pc[t*PC_W +: PC_W]        = ev.pc;
    end

    assign stage_active = |busy;

    // R10: any squashing lane keeps the stage active
    p_active_covers_r10: assert property (@(posedge clk) disable iff (rst)
        (|rob_squashing) |-> stage_active);

endmodule

// File: tb/squash_trap_ctrl_bench.sv
`timescale 1ns/1ps
module squash_trap_ctrl_bench;
    import sqtc_pkg::*;

    localparam int NT = 2;
    localparam int LW = 8;

    logic                clk = 1'b0;
    logic                rst;
    logic [LW-1:0]       trap_latency;
    logic [NT-1:0]       trap_req, trap_fetch, ctx_squash_req;
    logic [NT-1:0]       ex_squash_vld, ex_squash_incl, ex_squash_mispred;
    logic [NT*SEQ_W-1:0] ex_squash_seq, insert_seq, head_seq;
    logic [NT*PC_W-1:0]  ex_redirect_pc, commit_pc;
    logic [NT-1:0]       insert_vld, head_vld, rob_done;
    logic [NT-1:0]       sq_valid, sq_mispred, rob_squashing;
    logic [NT*SEQ_W-1:0] sq_seq;
    logic [NT*PC_W-1:0]  sq_pc;
    logic                stage_active;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    squash_trap_ctrl #(.NTHR(NT), .LAT_W(LW)) u_squash_trap_ctrl (
        .clk(clk), .rst(rst), .trap_latency(trap_latency),
        .trap_req(trap_req), .trap_fetch(trap_fetch),
        .ctx_squash_req(ctx_squash_req), .ex_squash_vld(ex_squash_vld),
        .ex_squash_seq(ex_squash_seq), .ex_squash_incl(ex_squash_incl),
        .ex_squash_mispred(ex_squash_mispred), .ex_redirect_pc(ex_redirect_pc),
        .insert_vld(insert_vld), .insert_seq(insert_seq),
        .head_vld(head_vld), .head_seq(head_seq), .commit_pc(commit_pc),
        .rob_done(rob_done), .sq_valid(sq_valid), .sq_seq(sq_seq),
        .sq_pc(sq_pc), .sq_mispred(sq_mispred),
        .rob_squashing(rob_squashing), .stage_active(stage_active)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        trap_req = '0; trap_fetch = '0; ctx_squash_req = '0;
        ex_squash_vld = '0; ex_squash_incl = '0; ex_squash_mispred = '0;
        insert_vld = '0; rob_done = '0;
    endtask

    task automatic ex0(input logic [SEQ_W-1:0] s, input logic incl, input logic mis,
                       input logic [PC_W-1:0] pc);
        ex_squash_vld[0] = 1'b1; ex_squash_seq[0 +: SEQ_W] = s;
        ex_squash_incl[0] = incl; ex_squash_mispred[0] = mis;
        ex_redirect_pc[0 +: PC_W] = pc;
    endtask

    task automatic ins0(input logic [SEQ_W-1:0] s);
        insert_vld[0] = 1'b1; insert_seq[0 +: SEQ_W] = s;
    endtask

    task automatic finish_squash0();
        rob_done[0] = 1'b1; tick(); clr();
    endtask

    task automatic t_reset();
        chk("R1 sq_valid", 32'(sq_valid), 0);
        chk("R1 rob_squashing", 32'(rob_squashing), 0);
        chk("R1 stage_active", 32'(stage_active), 0);
    endtask

    task automatic t_exec_squash();
        ins0(16'd10); tick(); clr();
        ex0(16'd12, 1'b0, 1'b1, 32'h100); tick(); clr();
        chk("R4 younger rejected", 32'(sq_valid[0]), 0);
        ex0(16'd7, 1'b0, 1'b1, 32'h200); tick(); clr();
        chk("R3 pulse", 32'(sq_valid[0]), 1);
        chk("R3 boundary", 32'(sq_seq[0 +: SEQ_W]), 7);
        chk("R3 pc", sq_pc[0 +: PC_W], 32'h200);
        chk("R3 mispred", 32'(sq_mispred[0]), 1);
        chk("R3 rob_squashing", 32'(rob_squashing[0]), 1);
        chk("R10 active while squashing", 32'(stage_active), 1);
        tick();
        chk("R3 pulse one cycle", 32'(sq_valid[0]), 0);
        chk("R6 held until done", 32'(rob_squashing[0]), 1);
        ex0(16'd5, 1'b1, 1'b0, 32'h300); tick(); clr();
        chk("R5 include-self pulse", 32'(sq_valid[0]), 1);
        chk("R5 boundary minus one", 32'(sq_seq[0 +: SEQ_W]), 4);
        chk("R5 mispred forwarded", 32'(sq_mispred[0]), 0);
        ins0(16'd50); tick(); clr();
        finish_squash0();
        chk("R6 flag drops after done", 32'(rob_squashing[0]), 0);
        chk("R10 inactive when idle work", 32'(stage_active), 0);
        ex0(16'd40, 1'b0, 1'b0, 32'h400); tick(); clr();
        chk("R7 insert during squash ignored", 32'(sq_valid[0]), 0);
        ex0(16'd5, 1'b0, 1'b0, 32'h400); tick(); clr();
        chk("R5 youngest is boundary", 32'(sq_valid[0]), 0);
        ins0(16'd60); tick(); clr();
        ex0(16'd55, 1'b0, 1'b0, 32'h500); tick(); clr();
        chk("R7 insert sets youngest", 32'(sq_valid[0]), 1);
        finish_squash0();
    endtask

    task automatic t_ctx_squash();
        head_vld[0] = 1'b1; head_seq[0 +: SEQ_W] = 16'd20;
        commit_pc[0 +: PC_W] = 32'hA0;
        ctx_squash_req[0] = 1'b1; tick(); clr();
        chk("R8 pulse", 32'(sq_valid[0]), 1);
        chk("R8 boundary head-1", 32'(sq_seq[0 +: SEQ_W]), 19);
        chk("R8 commit pc", sq_pc[0 +: PC_W], 32'hA0);
        chk("R8 no mispred", 32'(sq_mispred[0]), 0);
        finish_squash0();
        head_vld[0] = 1'b0;
        ctx_squash_req[0] = 1'b1; tick(); clr();
        chk("R8 empty boundary zero", 32'(sq_seq[0 +: SEQ_W]), 0);
        finish_squash0();
        ex0(16'd1, 1'b0, 1'b0, 32'h1); tick(); clr();
        chk("R8 youngest reset to zero", 32'(sq_valid[0]), 0);
    endtask

    task automatic t_trap_latency();
        trap_latency = 8'd3;
        ins0(16'd30); tick(); clr();
        head_vld[0] = 1'b1; head_seq[0 +: SEQ_W] = 16'd25;
        commit_pc[0 +: PC_W] = 32'hB0;
        trap_req[0] = 1'b1; tick(); clr();
        chk("R9 no early pulse n", 32'(sq_valid[0]), 0);
        chk("R10 active during trap", 32'(stage_active), 1);
        ex0(16'd5, 1'b0, 1'b0, 32'h9); tick(); clr();
        chk("R4 trap blocks exec squash", 32'(sq_valid[0]), 0);
        trap_req[0] = 1'b1; tick(); clr();
        chk("R9 no early pulse n+2", 32'(sq_valid[0]), 0);
        tick();
        chk("R9 no early pulse n+3", 32'(sq_valid[0]), 0);
        tick();
        chk("R9 pulse at n+L+1", 32'(sq_valid[0]), 1);
        chk("R9 trap boundary", 32'(sq_seq[0 +: SEQ_W]), 24);
        chk("R9 trap pc", sq_pc[0 +: PC_W], 32'hB0);
        finish_squash0();
        begin
            int extra = 0;
            for (int i = 0; i < 6; i++) begin
                tick();
                if (sq_valid[0]) extra++;
            end
            chk("R9 repeated request ignored", 32'(extra), 0);
        end
    endtask

    task automatic t_fetch_trap();
        trap_latency = 8'd3;
        ins0(16'd40); tick(); clr();
        trap_req[0] = 1'b1; trap_fetch[0] = 1'b1; tick(); clr();
        chk("R12 waiting, not squashing", 32'(rob_squashing[0]), 0);
        ex0(16'd12, 1'b0, 1'b1, 32'hC0); tick(); clr();
        chk("R12 exec squash accepted", 32'(sq_valid[0]), 1);
        chk("R12 boundary", 32'(sq_seq[0 +: SEQ_W]), 12);
        finish_squash0();
        begin
            int extra = 0;
            for (int i = 0; i < 6; i++) begin
                tick();
                if (sq_valid[0]) extra++;
            end
            chk("R12 wait cancelled", 32'(extra), 0);
        end
    endtask

    task automatic t_trap_ctx_rank();
        trap_latency = 8'd3;
        head_vld[0] = 1'b0;
        ins0(16'd40); tick(); clr();
        trap_req[0] = 1'b1; tick(); clr();
        tick();
        ctx_squash_req[0] = 1'b1; tick(); clr();
        chk("R2 context squashes during wait", 32'(sq_valid[0]), 1);
        finish_squash0();
        begin
            int extra = 0;
            for (int i = 0; i < 6; i++) begin
                tick();
                if (sq_valid[0]) extra++;
            end
            chk("R2 context cancels trap", 32'(extra), 0);
        end
        trap_latency = 8'd0;
        trap_req[0] = 1'b1; tick(); clr();
        ctx_squash_req[0] = 1'b1; tick(); clr();
        chk("R2 coincident single pulse", 32'(sq_valid[0]), 1);
        tick();
        chk("R2 no second pulse", 32'(sq_valid[0]), 0);
        finish_squash0();
    endtask

    task automatic t_lanes();
        insert_vld[1] = 1'b1; insert_seq[SEQ_W +: SEQ_W] = 16'd100; tick(); clr();
        ex_squash_vld[1] = 1'b1; ex_squash_seq[SEQ_W +: SEQ_W] = 16'd90;
        ex_squash_incl[1] = 1'b1; ex_redirect_pc[PC_W +: PC_W] = 32'hD0;
        tick(); clr();
        chk("R11 lane pattern", 32'(sq_valid), 32'h2);
        chk("R11 lane1 boundary", 32'(sq_seq[SEQ_W +: SEQ_W]), 89);
        chk("R11 lane0 untouched", 32'(rob_squashing[0]), 0);
        rob_done[1] = 1'b1; tick(); clr();
        chk("R11 lane1 done", 32'(rob_squashing), 0);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        trap_latency = 8'd3;
        ex_squash_seq = '0; insert_seq = '0; head_seq = '0;
        ex_redirect_pc = '0; commit_pc = '0; head_vld = '0;
        clr();
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_exec_squash();
        t_ctx_squash();
        t_trap_latency();
        t_fetch_trap();
        t_trap_ctx_rank();
        t_lanes();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule